// File: doc/BRIEF.md
# Boundary-Scan Register with Shared Mode Control

This block is the boundary-scan data register of a JTAG-style test port. It is a chain of identical cells, one for each device pin. Each cell has a serial path and a parallel path. On the serial side, a shift stage takes data from the neighbour nearer the test-data input and passes it to the neighbour nearer the test-data output. On the parallel side, the cell either passes the functional pin value through or drives the value held in its own update latch.

The TAP controller supplies three state levels: capture-DR, shift-DR and update-DR. It also supplies a test-logic-reset level and the current instruction code. A small decoder turns the instruction into two signals. The first is a select that lets the three state levels reach the cells as strobes. The second is a single MODE signal that every cell shares and that picks the source of its parallel output. No separate input-mode and output-mode controls exist. All storage runs from TCK. Shift stages move on the rising edge, and update latches load on the falling edge, so the parallel outputs change only during update.

Top module: `bsr_chain`

## Requirements
- R1: When the instruction selects the register and capture-DR is high, each shift stage loads its cell's parallel input on the rising TCK edge. Capture takes priority over shift.
- R2: When the register is selected and shift-DR is high, each rising TCK edge does three things: it moves tdi into stage CHAIN_LEN-1, it moves every stage i+1 into stage i, and it drops stage 0. tdo always shows stage 0, so the bit captured from pin 0 appears first.
- R3: The update latches load from the shift stages on the falling TCK edge while update-DR is high and the register is selected. At no other time do they change, so shifting leaves the parallel outputs untouched.
- R4: MODE is 1 for the EXTEST and INTEST codes, and every parallel output then equals its update latch. MODE is 0 for the SAMPLE code, and every parallel output then equals its parallel input.
- R5: For any instruction code other than EXTEST, SAMPLE or INTEST, all three strobes are inactive. Capture, shift and update then change neither the shift stages (seen at tdo) nor the update latches (seen later under EXTEST).
- R6: While test-logic-reset is high, all update latches and shift stages clear to 0 and MODE is forced to 0, so every parallel output equals its parallel input. After release under EXTEST, the parallel outputs read 0.
- R7: The default instruction codes are EXTEST = 4'b0000, SAMPLE = 4'b0001 and INTEST = 4'b0010. Code 4'b1111 selects nothing.
- R8: The chain length CHAIN_LEN is a parameter of at least 2, and the instruction width IR_W is a parameter of at least 2. The three codes must be distinct, and an elaboration-time check rejects any setting that breaks these rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr_i | input | 1 | TAP in test-logic-reset (asynchronous clear) |
| capture_dr_i | input | 1 | TAP in capture-DR |
| shift_dr_i | input | 1 | TAP in shift-DR |
| update_dr_i | input | 1 | TAP in update-DR |
| instr_i | input | IR_W | Current instruction code |
| tdi_i | input | 1 | Serial test data in (MSB end) |
| pin_i | input | CHAIN_LEN | Functional parallel inputs |
| pin_o | output | CHAIN_LEN | Parallel outputs toward the pads |
| tdo_o | output | 1 | Serial test data out (LSB end) |

## Verification
The bench uses an 8-cell chain and runs through all 256 capture patterns. For each pattern it shifts in a different pattern derived from the first by arithmetic. Because captured and shifted data differ, reading tdo before every shift shows whether bit order and direction are right. Reading pin_o after update shows whether the latches took the shifted data rather than the captured data. Alternating EXTEST and INTEST across the sweep, and checking pin_o before each update, confirms that both codes set MODE and that shifting leaves the latches alone. A closing pass under an unselected code, and then under reset, confirms that strobe gating and clearing leave the expected values at tdo and pin_o.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   localparam int unsigned BSR_IR_W_DEF = 4;
   localparam logic [BSR_IR_W_DEF-1:0] BSR_OP_EXTEST = 4'b0000;
   localparam logic [BSR_IR_W_DEF-1:0] BSR_OP_SAMPLE = 4'b0001;
   localparam logic [BSR_IR_W_DEF-1:0] BSR_OP_INTEST = 4'b0010;

   typedef struct packed {
      logic cap;
      logic shf;
      logic upd;
   } bsr_strobe_t;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
   import bsr_pkg::*;
#(
   parameter int unsigned IR_W = BSR_IR_W_DEF,
   parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(BSR_OP_EXTEST),
   parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(BSR_OP_SAMPLE),
   parameter logic [IR_W-1:0] OP_INTEST = IR_W'(BSR_OP_INTEST),
   parameter bit HAS_INTEST = 1'b1
) (
   input  logic [IR_W-1:0] instr_i,
   input  logic            tlr_i,
   input  logic            capture_dr_i,
   input  logic            shift_dr_i,
   input  logic            update_dr_i,
   output logic            mode_o,
   output logic            sel_o,
   output bsr_strobe_t     strobe_o
);
   logic hit_ext, hit_smp, hit_int;

   assign hit_ext = (instr_i == OP_EXTEST);
   assign hit_smp = (instr_i == OP_SAMPLE);

   generate
      if (HAS_INTEST) begin : g_intest
         assign hit_int = (instr_i == OP_INTEST);
      end else begin : g_no_intest
         assign hit_int = 1'b0;
      end
   endgenerate

   always_comb begin
      sel_o        = (hit_ext | hit_smp | hit_int) & ~tlr_i;
      mode_o       = (hit_ext | hit_int) & ~tlr_i;
      strobe_o.cap = capture_dr_i & sel_o;
      strobe_o.shf = shift_dr_i & sel_o & ~capture_dr_i;
      strobe_o.upd = update_dr_i & sel_o;
   end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
   input  logic tck,
   input  logic tlr_i,
   input  logic cap_i,
   input  logic shf_i,
   input  logic upd_i,
   input  logic mode_i,
   input  logic si_i,
   input  logic pi_i,
   output logic so_o,
   output logic upd_q_o,
   output logic po_o
);
   logic stage_q;
   logic hold_q;

   always_ff @(posedge tck or posedge tlr_i) begin
      if (tlr_i)      stage_q <= 1'b0;
      else if (cap_i) stage_q <= pi_i;
      else if (shf_i) stage_q <= si_i;
   end

   always_ff @(negedge tck or posedge tlr_i) begin
      if (tlr_i)      hold_q <= 1'b0;
      else if (upd_i) hold_q <= stage_q;
   end

   assign so_o    = stage_q;
   assign upd_q_o = hold_q;
   assign po_o    = mode_i ? hold_q : pi_i;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 8,
   parameter int unsigned IR_W = BSR_IR_W_DEF,
   parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(BSR_OP_EXTEST),
   parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(BSR_OP_SAMPLE),
   parameter logic [IR_W-1:0] OP_INTEST = IR_W'(BSR_OP_INTEST),
   parameter bit HAS_INTEST = 1'b1
) (
   input  logic                 tck,
   input  logic                 tlr_i,
   input  logic                 capture_dr_i,
   input  logic                 shift_dr_i,
   input  logic                 update_dr_i,
   input  logic [IR_W-1:0]      instr_i,
   input  logic                 tdi_i,
   input  logic [CHAIN_LEN-1:0] pin_i,
   output logic [CHAIN_LEN-1:0] pin_o,
   output logic                 tdo_o
);
   localparam int unsigned MSB = CHAIN_LEN - 1;

   // R8 elaboration-time parameter checks
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("bsr_chain: CHAIN_LEN must be at least 2");
      end
      if (IR_W < 2) begin : g_bad_irw
         $error("bsr_chain: IR_W must be at least 2");
      end
      if (OP_EXTEST == OP_SAMPLE || OP_EXTEST == OP_INTEST || OP_SAMPLE == OP_INTEST) begin : g_bad_ops
         $error("bsr_chain: instruction codes must be distinct");
      end
   endgenerate

   logic                 mode_w;
   logic                 sel_w;
   bsr_strobe_t          stb_w;
   logic [CHAIN_LEN-1:0] so_w;
   logic [CHAIN_LEN-1:0] si_w;
   logic [CHAIN_LEN-1:0] upd_w;

   bsr_decode #(
      .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
      .OP_INTEST(OP_INTEST), .HAS_INTEST(HAS_INTEST)
   ) dec_i (
      .instr_i(instr_i), .tlr_i(tlr_i), .capture_dr_i(capture_dr_i),
      .shift_dr_i(shift_dr_i), .update_dr_i(update_dr_i),
      .mode_o(mode_w), .sel_o(sel_w), .strobe_o(stb_w)
   );

   genvar gi;
   generate
      for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_cell
         if (gi == MSB) begin : g_head
            assign si_w[gi] = tdi_i;
         end else begin : g_body
            assign si_w[gi] = so_w[gi+1];
         end
         bsr_cell cell_i (
            .tck(tck), .tlr_i(tlr_i), .cap_i(stb_w.cap), .shf_i(stb_w.shf),
            .upd_i(stb_w.upd), .mode_i(mode_w), .si_i(si_w[gi]), .pi_i(pin_i[gi]),
            .so_o(so_w[gi]), .upd_q_o(upd_w[gi]), .po_o(pin_o[gi])
         );
      end
   endgenerate

   assign tdo_o = so_w[0];

   AST_CAPTURE_LOADS: assert property (@(posedge tck) disable iff (tlr_i)
      (capture_dr_i && sel_w) |=> (so_w == $past(pin_i)));                // R1
   AST_SHIFT_HEAD: assert property (@(posedge tck) disable iff (tlr_i)
      (shift_dr_i && !capture_dr_i && sel_w) |=> (so_w[MSB] == $past(tdi_i))); // R2
   AST_SHIFT_TAIL: assert property (@(posedge tck) disable iff (tlr_i)
      (shift_dr_i && !capture_dr_i && sel_w) |=> (tdo_o == $past(so_w[1]))); // R2
   AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (tlr_i)
      (!update_dr_i) |-> $stable(upd_w));                                  // R3
   AST_SAMPLE_PASS: assert property (@(posedge tck) disable iff (tlr_i)
      (instr_i == OP_SAMPLE) |-> (pin_o == pin_i));                        // R4
   AST_UNSEL_FROZEN: assert property (@(posedge tck) disable iff (tlr_i)
      (!sel_w) |=> $stable(so_w));                                         // R5
endmodule

// File: tb/bsr_chain_tb.sv
`timescale 1ns/1ps
module bsr_chain_tb_top;
   localparam int N = 8;
   localparam logic [3:0] C_EXT = 4'b0000;
   localparam logic [3:0] C_SMP = 4'b0001;
   localparam logic [3:0] C_INT = 4'b0010;
   localparam logic [3:0] C_BYP = 4'b1111;

   logic tck = 1'b0;
   logic tlr, cap, shf, upd, tdi, tdo;
   logic [3:0] instr;
   logic [N-1:0] pin_i, pin_o;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 tck = ~tck;

   bsr_chain #(.CHAIN_LEN(N), .IR_W(4)) dut_i (
      .tck(tck), .tlr_i(tlr), .capture_dr_i(cap), .shift_dr_i(shf),
      .update_dr_i(upd), .instr_i(instr), .tdi_i(tdi), .pin_i(pin_i),
      .pin_o(pin_o), .tdo_o(tdo)
   );

   task automatic tick();
      @(posedge tck);
      #1;
   endtask

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_capture();
      cap = 1'b1; tick(); cap = 1'b0;
   endtask

   task automatic do_update();
      upd = 1'b1; tick(); upd = 1'b0;
   endtask

   initial begin
      logic [N-1:0] lat;
      logic [N-1:0] q;
      tlr = 1'b1; cap = 0; shf = 0; upd = 0; tdi = 0;
      instr = C_EXT; pin_i = 8'hA5;
      tick(); tick();
      // R6: reset forces MODE to 0 even with EXTEST present
      chk("R6 reset passthrough", pin_o, 8'hA5);
      tlr = 1'b0; #1;
      chk("R6 latches cleared", pin_o, '0);
      lat = '0;

      for (int p = 0; p < 256; p++) begin
         q = N'((p * 113 + 29) ^ 8'h5A);
         instr = C_SMP; pin_i = N'(p); #1;
         chk("R4 sample passthrough", pin_o, N'(p));
         do_capture();
         // R1 and R2: captured bits leave tdo LSB first
         for (int j = 0; j < N; j++) begin
            chk(j == 0 ? "R1 capture" : "R2 shift order", {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, p[j]});
            shf = 1'b1; tdi = q[j]; tick(); shf = 1'b0;
         end
         instr = (p % 2 == 0) ? C_EXT : C_INT; pin_i = ~N'(p); #1;
         chk("R3 hold during shift", pin_o, lat);
         do_update();
         lat = q;
         chk((p % 2 == 0) ? "R3 update extest" : "R4 update intest", pin_o, lat);
         chk("R2 shifted into stage0", {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, q[0]});
      end

      // R5 and R7: unselected code blocks every strobe
      instr = C_BYP; pin_i = ~lat; #1;
      chk("R5 bypass passthrough", pin_o, ~lat);
      do_capture();
      chk("R5 capture blocked", {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, lat[0]});
      for (int j = 0; j < 3; j++) begin
         shf = 1'b1; tdi = ~lat[N-1-j]; tick(); shf = 1'b0;
      end
      chk("R5 shift blocked", {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, lat[0]});
      do_update();
      instr = C_EXT; #1;
      chk("R5 update blocked", pin_o, lat);

      // R6: reset with nonzero latches
      tlr = 1'b1; pin_i = 8'h3C; #1;
      chk("R6 reset mode zero", pin_o, 8'h3C);
      tick();
      tlr = 1'b0; #1;
      chk("R6 latches zero after release", pin_o, '0);
      chk("R6 stage zero", {{(N-1){1'b0}}, tdo}, '0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule